// File: doc/BRIEF.md
# Encoded 32-bit Integer ALU

This block is a purely combinational integer arithmetic logic unit. It takes two operand words and a 4-bit operation code, and it returns one result word in the same cycle. A datapath places it between its operand muxes and its write-back path. The block holds no state and takes no clock.

The operation set covers wrapping add and subtract, the three bitwise logic operations, and three shifts: left, logical right and arithmetic right. It also covers a signed less-than compare, unsigned quotient and remainder, the low product word, and the high product word with operands taken as unsigned or as signed. A pass-through of the second operand completes the set. There are no flag, carry or overflow outputs. The results of divide and remainder by zero are fixed, so a caller never has to special-case a zero divisor.

Top module: `int_alu`

## Requirements
- R1: With `op_sel` = 0, `result` is `opa + opb` truncated to 32 bits, and overflow wraps silently.
- R2: `op_sel` = 1 gives `opa & opb`, 2 gives `opa | opb`, and 3 gives `opa ^ opb`.
- R3: With `op_sel` = 4, `result` is `opa` shifted right by `opb[4:0]` with zeros filling from the top. The upper bits `opb[31:5]` are ignored by every shift.
- R4: With `op_sel` = 5, `result` is `opa` shifted right by `opb[4:0]`, with copies of `opa[31]` filling from the top.
- R5: With `op_sel` = 6, `result` is `opa` shifted left by `opb[4:0]` with zeros filling from the bottom.
- R6: With `op_sel` = 7, `result` is 1 when `opa` < `opb` as signed two's-complement values, and 0 otherwise.
- R7: With `op_sel` = 8, `result` is the unsigned quotient `opa / opb`. A zero divisor yields 0xFFFFFFFF.
- R8: With `op_sel` = 9, `result` is the unsigned remainder `opa % opb`. A zero divisor yields `opa`.
- R9: With `op_sel` = 10, `result` is bits 31:0 of the product `opa * opb`.
- R10: With `op_sel` = 11, `result` is bits 63:32 of the 64-bit product, with both operands taken as unsigned.
- R11: With `op_sel` = 14, `result` is bits 63:32 of the 64-bit product, with both operands taken as signed.
- R12: With `op_sel` = 12, `result` is `opa - opb` truncated to 32 bits, and borrow wraps silently.
- R13: With `op_sel` = 13, `result` equals `opb`.
- R14: `op_sel` = 15 is unused and gives `result` = 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; for shifts, bits 4:0 give the shift amount |
| op_sel | input | 4 | Operation code, encoded as listed in the requirements |
| result | output | 32 | Result word of the selected operation |

## Verification
The hardest cases to reach are the ones where the signed high product differs from the unsigned one. These need one or both operands negative, including the most negative value times itself and times -1. The other hard cases are the shifts where `opb` carries set bits above bit 4, which must be masked off. Random operands seldom land on these cases. The stimulus therefore crosses every code with a fixed set of boundary words: 0, 1, all ones, the sign bit alone, the largest positive value, 31, 32 and 0x21. Random pairs are then added for breadth. Zero divisors are reached by the boundary set, since 0 appears as the second operand for every code.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_SRL   = 4'd4,
    OP_SRA   = 4'd5,
    OP_SLL   = 4'd6,
    OP_SLT   = 4'd7,
    OP_DIVU  = 4'd8,
    OP_REMU  = 4'd9,
    OP_MUL   = 4'd10,
    OP_MULHU = 4'd11,
    OP_SUB   = 4'd12,
    OP_PASSB = 4'd13,
    OP_MULH  = 4'd14,
    OP_NONE  = 4'd15
  } alu_op_e;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   src,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   srl_out,
  output logic [W-1:0]   sra_out,
  output logic [W-1:0]   sll_out
);

  function automatic logic [W-1:0] shr_fill(input logic [W-1:0] v,
                                            input logic [SHW-1:0] n,
                                            input logic fill);
    logic [2*W-1:0] wide;
    wide = {{W{fill}}, v} >> n;
    return wide[W-1:0];
  endfunction

  assign srl_out = shr_fill(src, amt, 1'b0);
  assign sra_out = shr_fill(src, amt, src[W-1]);
  assign sll_out = src << amt;

  always_comb begin
    if (!$isunknown({src, amt})) begin
      // R3
      srl_vs_sra_chk: assert (src[W-1] || (srl_out == sra_out));
      // R4
      sra_sign_chk: assert (sra_out[W-1] == src[W-1]);
      // R3
      srl_fill_chk: assert ((amt == '0) || !srl_out[W-1]);
    end
  end

endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi_u,
  output logic [W-1:0] hi_s
);

  logic [PW-1:0] prod_u;
  logic signed [PW-1:0] prod_s_chk;

  // The signed high word is the unsigned one minus a correction term for each negative operand.
  function automatic logic [W-1:0] signed_hi(input logic [W-1:0] hu,
                                             input logic [W-1:0] x,
                                             input logic [W-1:0] y);
    logic [W-1:0] cx, cy;
    cx = x[W-1] ? y : '0;
    cy = y[W-1] ? x : '0;
    return hu - cx - cy;
  endfunction

  assign prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign lo     = prod_u[W-1:0];
  assign hi_u   = prod_u[PW-1:W];
  assign hi_s   = signed_hi(hi_u, a, b);

  assign prod_s_chk = $signed(a) * $signed(b);

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R11
      mulh_corr_chk: assert (hi_s == prod_s_chk[PW-1:W]);
      // R9
      mul_low_chk: assert (lo == prod_s_chk[W-1:0]);
    end
  end

endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  function automatic logic [W-1:0] udiv(input logic [W-1:0] x, input logic [W-1:0] y);
    return (y == '0) ? '1 : x / y;
  endfunction

  function automatic logic [W-1:0] urem(input logic [W-1:0] x, input logic [W-1:0] y);
    return (y == '0) ? x : x % y;
  endfunction

  assign quo = udiv(num, den);
  assign rem = urem(num, den);

  logic [PW-1:0] rebuild;
  assign rebuild = {{W{1'b0}}, quo} * {{W{1'b0}}, den} + {{W{1'b0}}, rem};

  always_comb begin
    if (!$isunknown({num, den}) && (den != '0)) begin
      // R7
      div_identity_chk: assert (rebuild == {{W{1'b0}}, num});
      // R8
      rem_bound_chk: assert (rem < den);
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result
);

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  logic [W-1:0] srl_w, sra_w, sll_w;
  logic [W-1:0] mul_lo_w, mul_hu_w, mul_hs_w;
  logic [W-1:0] quo_w, rem_w;
  logic         lt_signed;

  alu_shifter #(.W(W)) u_shift (
    .src     (opa),
    .amt     (opb[SHW-1:0]),
    .srl_out (srl_w),
    .sra_out (sra_w),
    .sll_out (sll_w)
  );

  alu_multiplier #(.W(W)) u_mul (
    .a    (opa),
    .b    (opb),
    .lo   (mul_lo_w),
    .hi_u (mul_hu_w),
    .hi_s (mul_hs_w)
  );

  alu_divider #(.W(W)) u_div (
    .num (opa),
    .den (opb),
    .quo (quo_w),
    .rem (rem_w)
  );

  assign lt_signed = $signed(opa) < $signed(opb);

  always_comb begin
    unique case (op)
      OP_ADD:   result = opa + opb;
      OP_AND:   result = opa & opb;
      OP_OR:    result = opa | opb;
      OP_XOR:   result = opa ^ opb;
      OP_SRL:   result = srl_w;
      OP_SRA:   result = sra_w;
      OP_SLL:   result = sll_w;
      OP_SLT:   result = {{(W-1){1'b0}}, lt_signed};
      OP_DIVU:  result = quo_w;
      OP_REMU:  result = rem_w;
      OP_MUL:   result = mul_lo_w;
      OP_MULHU: result = mul_hu_w;
      OP_SUB:   result = opa - opb;
      OP_PASSB: result = opb;
      OP_MULH:  result = mul_hs_w;
      default:  result = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opa, opb, op_sel})) begin
      // R6
      slt_bin_chk: assert ((op != OP_SLT) || (result[W-1:1] == '0));
      // R14
      unused_zero_chk: assert ((op != OP_NONE) || (result == '0));
      // R12
      sub_inverse_chk: assert ((op != OP_SUB) || ((result + opb) == opa));
    end
  end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [3:0]  op_sel = '0;
  logic [31:0] result;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  int_alu u_int_alu (.opa(opa), .opb(opb), .op_sel(op_sel), .result(result));

  function automatic string tag_of(input int s);
    case (s)
      0: return "R1";   1, 2, 3: return "R2";  4: return "R3";  5: return "R4";
      6: return "R5";   7: return "R6";        8: return "R7";  9: return "R8";
      10: return "R9";  11: return "R10";      12: return "R12"; 13: return "R13";
      14: return "R11"; default: return "R14";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input int s);
    longint          sa = longint'($signed(a));
    longint          sb = longint'($signed(b));
    longint unsigned ua = 64'(a);
    longint unsigned ub = 64'(b);
    longint          ps = sa * sb;
    longint unsigned pu = ua * ub;
    int              sh = int'(b & 32'h1f);
    case (s)
      0:  return 32'(ua + ub);
      1:  return a & b;
      2:  return a | b;
      3:  return a ^ b;
      4:  return 32'(ua >> sh);
      5:  return 32'(sa >>> sh);
      6:  return 32'(ua << sh);
      7:  return (sa < sb) ? 32'd1 : 32'd0;
      8:  return (b == 0) ? 32'hFFFF_FFFF : 32'(ua / ub);
      9:  return (b == 0) ? a : 32'(ua % ub);
      10: return 32'(pu);
      11: return 32'(pu >> 32);
      12: return 32'(ua - ub);
      13: return b;
      14: return 32'(ps >>> 32);
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input int s);
    logic [31:0] exp;
    @(negedge clk);
    opa = a; opb = b; op_sel = 4'(s);
    exp = model(a, b, s);
    @(posedge clk);
    n_tests++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h got=%h expected=%h", tag_of(s), s, a, b, result, exp);
    end
  endtask

  logic [31:0] corners [8];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h0000_001F;
    corners[6] = 32'h0000_0020; corners[7] = 32'h0000_0021;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero operands with code 0 give zero (R1)
    apply(32'd0, 32'd0, 0);
    // directed boundary cases
    apply(32'hFFFF_FFFF, 32'd1, 0);          // R1 wrap
    apply(32'd0, 32'd1, 12);                 // R12 borrow wrap
    apply(32'h8000_0000, 32'hFFFF_FFE4, 5);  // R4 amount 4 from low bits, R3 masking
    apply(32'h1234_5678, 32'd0, 8);          // R7 divide by zero
    apply(32'h1234_5678, 32'd0, 9);          // R8 remainder by zero
    apply(32'h8000_0000, 32'h8000_0000, 14); // R11 most negative squared
    apply(32'h8000_0000, 32'hFFFF_FFFF, 11); // R10
    apply(32'hDEAD_BEEF, 32'h1234_5678, 15); // R14
    apply(32'hFFFF_FFFF, 32'd0, 7);          // R6 -1 < 0
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(corners[i], corners[j], s);
    for (int k = 0; k < 300; k++)
      for (int s = 0; s < 16; s++)
        apply($urandom, $urandom, s);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete got=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule